// File: doc/BRIEF.md
# Strap-Sampled LED Pin Controller

This block owns five bidirectional pads that do two jobs. During reset each pad is an input. A board-level pull to the supply or to ground sets one bit of the PHY's management address. Once reset is released, the block captures those five levels as the management port address. It then turns the pads into LED drivers. The five LEDs show activity, collision, link integrity, transmit and receive.

The pull resistor that set an address bit is also part of that pad's LED circuit. For this reason the block decides the active drive level of each pad from the bit it latched there. An LED therefore lights correctly whichever rail its pad was strapped to.

Short status pulses, such as a single transmitted frame or a collision, would be too brief to see. Each of these indications is stretched by a per-LED counter of configurable length. Link integrity is shown as a steady level.

Top module: `strap_led_pins`

## Requirements
- R1: While `rstN` is low, `padOe` is 0 on all five pads and `phyAddr` reads 0.
- R2: At the first rising clock edge after `rstN` goes high, `phyAddr[n]` takes the level of `padIn[n]` for each n from 0 to 4. A pad pulled high gives 1 and a pad pulled low gives 0.
- R3: `padOe` stays 0 through that capture edge. All five bits rise together at the next edge and then stay at 1 until reset.
- R4: After capture, `phyAddr` holds its value until the next reset. Later pad levels have no effect on it.
- R5: When a pad's latched bit is 1, the pad drives 0 while its LED is lit and 1 while it is dark. When the bit is 0, the pad drives 1 while lit and 0 while dark.
- R6: The pad-to-LED mapping is fixed: pad 0 shows activity, pad 1 collision, pad 2 link integrity, pad 3 transmit and pad 4 receive. A status input affects only its own pad.
- R7: The activity, collision, transmit and receive indications are stretched. If the status is sampled high at a clock edge, that LED is lit during the STRETCH_CYCLES cycles that begin at that edge. A further high sample restarts the window.
- R8: The link LED is lit for exactly the cycle after each edge at which `linkIn` is sampled high. It has no stretching.
- R9: While `padOe` is 0, `padOut` is 0 on every pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; strap sampling window |
| actIn | input | 1 | Link activity indication |
| colIn | input | 1 | Collision indication |
| linkIn | input | 1 | Link integrity level |
| txIn | input | 1 | Transmit data indication |
| rxIn | input | 1 | Receive data indication |
| padIn | input | 5 | Level seen on each pad |
| padOut | output | 5 | Drive value for each pad |
| padOe | output | 5 | Output enable for each pad |
| phyAddr | output | 5 | Latched management port address |

## Verification
The address is due at the first edge after reset release, and the output enables are due one edge after that. Every registered LED level follows the status sampled at the preceding edge. A stretched LED stays lit through the STRETCH_CYCLES-th sample after its last high input.

The bench drives inputs on falling edges. A behavioural model updates on each rising edge. The design's outputs are compared with the model at the following falling edge, so each result is checked in the cycle it becomes due.

Directed checks pin the exact cycle of capture, of enable and of the last lit cycle of a stretched pulse.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int NUM_PADS = 5;
  localparam int PAD_ACT  = 0;
  localparam int PAD_COL  = 1;
  localparam int PAD_LINK = 2;
  localparam int PAD_TX   = 3;
  localparam int PAD_RX   = 4;
  // pads whose indication is pulse-stretched (link is shown as a level)
  localparam logic [NUM_PADS-1:0] STRETCH_MASK_DEF = 5'b11011;

  typedef struct packed {
    logic capture;   // latch strap levels this edge
    logic driveEn;   // turn pad drivers on this edge
  } strapStrobe_t;
endpackage

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output strapStrobe_t strobe
);
  typedef enum logic [1:0] {PH_SAMPLE, PH_ARM, PH_RUN} phase_t;
  phase_t phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SAMPLE;
    end else begin
      case (phase)
        PH_SAMPLE: phase <= PH_ARM;
        PH_ARM:    phase <= PH_RUN;
        default:   phase <= PH_RUN;
      endcase
    end
  end

  assign strobe.capture = (phase == PH_SAMPLE);
  assign strobe.driveEn = (phase == PH_ARM);
endmodule

// File: rtl/strap_led_datapath.sv
module strap_led_datapath
  import strap_led_pkg::*;
#(
  parameter int                    STRETCH_CYCLES = 8,
  parameter logic [NUM_PADS-1:0]   STRETCH_MASK   = STRETCH_MASK_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  strapStrobe_t        strobe,
  input  logic [NUM_PADS-1:0] statusIn,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_PADS-1:0] phyAddr
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);

  logic [NUM_PADS-1:0] addrQ;
  logic [NUM_PADS-1:0] oeQ;
  logic [NUM_PADS-1:0] ledOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      oeQ   <= '0;
    end else begin
      if (strobe.capture) addrQ <= padIn;
      if (strobe.driveEn) oeQ   <= '1;
    end
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    if (STRETCH_MASK[i]) begin : g_stretch
      logic [CNT_W-1:0] holdCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 holdCnt <= '0;
        else if (statusIn[i])      holdCnt <= CNT_LOAD;
        else if (holdCnt != '0)    holdCnt <= holdCnt - CNT_W'(1);
      end
      assign ledOn[i] = (holdCnt != '0);
    end else begin : g_level
      logic levelQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) levelQ <= 1'b0;
        else       levelQ <= statusIn[i];
      end
      assign ledOn[i] = levelQ;
    end
  end

  // a strap bit of 1 means the LED hangs from the high rail: sink to light it
  assign padOut  = oeQ & (ledOn ^ addrQ);
  assign padOe   = oeQ;
  assign phyAddr = addrQ;
endmodule

// File: rtl/strap_led_pins.sv
module strap_led_pins
  import strap_led_pkg::*;
#(
  parameter int STRETCH_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       actIn,
  input  logic       colIn,
  input  logic       linkIn,
  input  logic       txIn,
  input  logic       rxIn,
  input  logic [4:0] padIn,
  output logic [4:0] padOut,
  output logic [4:0] padOe,
  output logic [4:0] phyAddr
);
  strapStrobe_t        strobe;
  logic [NUM_PADS-1:0] statusIn;

  always_comb begin
    statusIn           = '0;
    statusIn[PAD_ACT]  = actIn;
    statusIn[PAD_COL]  = colIn;
    statusIn[PAD_LINK] = linkIn;
    statusIn[PAD_TX]   = txIn;
    statusIn[PAD_RX]   = rxIn;
  end

  strap_led_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  strap_led_datapath #(
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .STRETCH_MASK   (STRETCH_MASK_DEF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .statusIn (statusIn),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .phyAddr  (phyAddr)
  );
endmodule

// File: rtl/strap_led_checker.sv
module strap_led_checker (
  input logic       clk,
  input logic       rstN,
  input logic       linkIn,
  input logic [4:0] padOut,
  input logic [4:0] padOe,
  input logic [4:0] phyAddr
);
  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (padOe == 5'b0 && phyAddr == 5'b0); // R1
    end
  end

  AST_OE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (padOe != 5'b0) |-> (padOe == 5'h1f)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (padOe != 5'b0) |=> $stable(phyAddr)); // R4

  AST_LINK_LIT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (padOe[2] && $past(linkIn)) |-> (padOut[2] == ~phyAddr[2])); // R5

  AST_LINK_DARK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (padOe[2] && !$past(linkIn)) |-> (padOut[2] == phyAddr[2])); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (padOe == 5'b0) |-> (padOut == 5'b0)); // R9
endmodule

bind strap_led_pins strap_led_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .linkIn  (linkIn),
  .padOut  (padOut),
  .padOe   (padOe),
  .phyAddr (phyAddr)
);

// File: tb/strap_led_pins_tb.sv
module strap_led_pins_tb;
  localparam int STRETCH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic actIn = 0, colIn = 0, linkIn = 0, txIn = 0, rxIn = 0;
  logic [4:0] strap = 5'b10110;
  logic [4:0] padIn, padOut, padOe, phyAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  // board model: pad shows the strap pull unless the block drives it
  assign padIn = (padOe & padOut) | (~padOe & strap);

  strap_led_pins #(.STRETCH_CYCLES(STRETCH)) u_dut (
    .clk(clk), .rstN(rstN), .actIn(actIn), .colIn(colIn), .linkIn(linkIn),
    .txIn(txIn), .rxIn(rxIn), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .phyAddr(phyAddr)
  );

  // behavioural reference
  int   mStage;
  int   mCnt [5];
  bit   mLink, mOe;
  logic [4:0] mAddr;

  always @(posedge clk) begin
    logic [4:0] stim;
    stim = {rxIn, txIn, linkIn, colIn, actIn};
    if (!rstN) begin
      mStage = 0; mOe = 0; mAddr = 5'b0; mLink = 0;
      foreach (mCnt[i]) mCnt[i] = 0;
    end else begin
      if (mStage == 0) begin mAddr = strap; mStage = 1; end
      else if (mStage == 1) begin mOe = 1; mStage = 2; end
      for (int i = 0; i < 5; i++) begin
        if (i != 2) begin
          if (stim[i]) mCnt[i] = STRETCH;
          else if (mCnt[i] > 0) mCnt[i] = mCnt[i] - 1;
        end
      end
      mLink = stim[2];
    end
  end

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    chk("R4 addr", phyAddr, mAddr);
    chk("R3 oe", padOe, mOe ? 5'h1f : 5'h00);
    for (int i = 0; i < 5; i++) begin
      bit on;
      on = (i == 2) ? mLink : (mCnt[i] > 0);
      chk(i == 2 ? "R8 link pad" : "R7 stretched pad",
          {4'b0, padOut[i]}, {4'b0, mOe ? (on ^ mAddr[i]) : 1'b0});
    end
  endtask

  task automatic step();
    @(negedge clk);
    compareModel();
  endtask

  task automatic randomRun(input int n);
    for (int k = 0; k < n; k++) begin
      step();
      actIn  = ($urandom % 5) == 0;
      colIn  = ($urandom % 9) == 0;
      linkIn = ($urandom % 4) != 0;
      txIn   = ($urandom % 6) == 0;
      rxIn   = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) strap = 5'($urandom);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 oe in reset", padOe, 5'h00);
    chk("R1 addr in reset", phyAddr, 5'h00);
    chk("R9 out idle", padOut, 5'h00);
    rstN = 1'b1;
    step();
    chk("R2 captured addr", phyAddr, 5'b10110);
    chk("R3 oe still off", padOe, 5'h00);
    step();
    chk("R3 oe on", padOe, 5'h1f);
    linkIn = 1;
    step();
    chk("R5 polarity", padOut, 5'b10010);
    linkIn = 0; colIn = 1;
    step();
    chk("R6 collision only", padOut, 5'b10100);
    colIn = 0;
    repeat (5) step();
    chk("R7 last lit cycle", {4'b0, padOut[1]}, 5'b0);
    step();
    chk("R7 dark after stretch", {4'b0, padOut[1]}, 5'b1);
    strap = 5'b01001;
    repeat (4) step();
    chk("R4 pads ignored", phyAddr, 5'b10110);
    randomRun(300);
    rstN = 1'b0;
    step();
    chk("R1 oe in reset again", padOe, 5'h00);
    chk("R9 out idle again", padOut, 5'h00);
    strap = 5'b01001;
    rstN = 1'b1;
    step();
    chk("R2 second capture", phyAddr, 5'b01001);
    randomRun(400);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule